// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock for an I2C master by counting cycles of the peripheral clock. One shared 12-bit divider value sets a base unit. A mode bit and a duty bit then pick one of three high-to-low ratios: 1:1 for standard speed, 1:2 for fast speed, or 9:16 for fast speed with the alternate duty. The resulting phase lengths are loaded into a single down-counter that toggles the SCL drive level at the end of each phase.

Software sets the divider, mode and duty through two byte-wide configuration locations while the enable input is low. Writes made while the block is enabled are dropped, so the timing cannot change in the middle of a transfer. When the block is enabled, SCL starts with a complete high phase. When it is disabled, SCL is released high at once. A divider of zero never yields a zero-length phase: SCL stays high and an error flag is raised. A one-cycle strobe marks every falling and every rising SCL transition, so a byte engine can shift or sample data on it.

Top module: `scl_period_gen`

## Requirements
- R1: With mode=0 (standard), the high phase and the low phase each last CCR clock cycles.
- R2: With mode=1 and duty=0 (fast), the high phase lasts CCR cycles and the low phase lasts 2×CCR cycles.
- R3: With mode=1 and duty=1, the high phase lasts 9×CCR cycles and the low phase lasts 16×CCR cycles.
- R4: Configuration location 1 (cfg_addr=1) holds mode in bit 7, duty in bit 6 and CCR[11:8] in bits 3:0. Its bits 5:4 always read as zero. Location 0 holds CCR[7:0]. cfg_rdata shows the location selected by cfg_addr in the same cycle.
- R5: A write (cfg_we=1) made while enable=1 changes no configuration field, and so has no effect on the readback or on the phase timing.
- R6: After reset, every configuration field is zero, scl_o is 1, and scl_fall, scl_rise and cfg_err are 0.
- R7: While enabled with CCR=0, scl_o stays 1, no strobe is asserted, and cfg_err is 1 from the first clock edge that samples enable=1.
- R8: On enable, scl_o stays 1 for a full high phase. The first falling transition comes the high-phase length in cycles after the first clock edge that samples enable=1.
- R9: When enable goes low, scl_o is 1 after the next clock edge and no strobe is raised. The next enable begins again with a full high phase.
- R10: scl_fall is a one-cycle pulse in the cycle in which scl_o becomes 0. scl_rise is a one-cycle pulse in the cycle in which scl_o becomes 1 during a low-to-high phase change.
- R11: At the largest divider (CCR=4095, mode=1, duty=1), the phases last exactly 36855 and 65520 cycles, with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable; locks configuration while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration location select (0 low byte, 1 high byte) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the selected location |
| scl_o | output | 1 | SCL drive level (1 = released high) |
| scl_fall | output | 1 | One-cycle strobe on a high-to-low transition |
| scl_rise | output | 1 | One-cycle strobe on a low-to-high transition |
| cfg_err | output | 1 | Enabled with a zero divider |

## Verification
The assertions assume that reset is held from time zero until the first clock edges, and that enable, cfg_we and the write data change only between rising edges. The bench changes every input on the falling edge and keeps reset high from its declaration. The lock and stability properties also assume that configuration changes only through cfg_we. The bench touches no other path: after each write attempt it reads the state back through cfg_rdata and measures the SCL timing.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic {
    SPEED_STD  = 1'b0,
    SPEED_FAST = 1'b1
  } scl_speed_e;

  typedef enum logic [1:0] {
    RATIO_1_1  = 2'd0,
    RATIO_1_2  = 2'd1,
    RATIO_9_16 = 2'd2
  } scl_ratio_e;

  function automatic scl_ratio_e pick_ratio(input scl_speed_e speed, input logic duty);
    if (speed == SPEED_STD) return RATIO_1_1;
    else if (!duty)         return RATIO_1_2;
    else                    return RATIO_9_16;
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int CCR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output scl_speed_e       speed,
  output logic             duty,
  output logic [CCR_W-1:0] ccr
);
  localparam int HI_W  = CCR_W - 8;
  localparam int PAD_W = 6 - HI_W;

  logic unused_rsvd;
  assign unused_rsvd = ^cfg_wdata[5:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      speed <= SPEED_STD;
      duty  <= 1'b0;
      ccr   <= '0;
    end else if (cfg_we && !enable) begin
      if (cfg_addr) begin
        speed            <= scl_speed_e'(cfg_wdata[7]);
        duty             <= cfg_wdata[6];
        ccr[CCR_W-1:8]   <= cfg_wdata[HI_W-1:0];
      end else begin
        ccr[7:0]         <= cfg_wdata;
      end
    end
  end

  always_comb begin
    if (cfg_addr) cfg_rdata = {speed, duty, {PAD_W{1'b0}}, ccr[CCR_W-1:8]};
    else          cfg_rdata = ccr[7:0];
  end

  // R5: configuration frozen while enabled
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    enable |=> ($stable(speed) && $stable(duty) && $stable(ccr)));

endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len
  import scl_gen_pkg::*;
#(
  parameter int CCR_W = 12,
  parameter int CNT_W = CCR_W + 4
) (
  input  scl_speed_e       speed,
  input  logic             duty,
  input  logic [CCR_W-1:0] ccr,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] low_len,
  output logic             zero_ccr
);
  logic [CNT_W-1:0] base;
  scl_ratio_e       ratio;

  assign base     = {{(CNT_W-CCR_W){1'b0}}, ccr};
  assign ratio    = pick_ratio(speed, duty);
  assign zero_ccr = (ccr == '0);

  always_comb begin
    unique case (ratio)
      RATIO_1_2: begin
        high_len = base;
        low_len  = base << 1;
      end
      RATIO_9_16: begin
        high_len = (base << 3) + base;
        low_len  = base << 4;
      end
      default: begin
        high_len = base;
        low_len  = base;
      end
    endcase
  end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             zero_ccr,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] low_len,
  output logic             scl_o,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             cfg_err
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      scl_o    <= 1'b1;
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      cfg_err  <= zero_ccr;
      if (zero_ccr) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        scl_o <= 1'b1;
      end else if (!run_q) begin
        run_q <= 1'b1;
        cnt_q <= high_len;
        scl_o <= 1'b1;
      end else if (cnt_q == ONE) begin
        scl_o    <= ~scl_o;
        cnt_q    <= scl_o ? low_len : high_len;
        scl_fall <= scl_o;
        scl_rise <= ~scl_o;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  // R10: strobes match the transition they mark
  a_r10_fall_marks_edge: assert property (@(posedge clk) disable iff (rst)
    scl_fall |-> (!scl_o && $past(scl_o)));
  a_r10_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
    scl_rise |-> (scl_o && !$past(scl_o)));
  a_r10_change_strobed: assert property (@(posedge clk) disable iff (rst)
    (scl_o != $past(scl_o)) |-> (scl_fall || scl_rise || !$past(enable)));
  // R9: disabled means released high, no strobes
  a_r9_off_released: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_o && !scl_fall && !scl_rise));
  // R7: zero divider holds SCL high
  a_r7_zero_holds: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (scl_o && !scl_fall && !scl_rise));
  // R11: running counter never wraps to zero
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CCR_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       cfg_we,
  input  logic       cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       scl_o,
  output logic       scl_fall,
  output logic       scl_rise,
  output logic       cfg_err
);
  localparam int CNT_W = CCR_W + 4;

  scl_speed_e       speed;
  logic             duty;
  logic [CCR_W-1:0] ccr;
  logic [CNT_W-1:0] high_len;
  logic [CNT_W-1:0] low_len;
  logic             zero_ccr;

  scl_cfg_regs #(.CCR_W(CCR_W)) u_regs (
    .clk(clk), .rst(rst), .enable(enable),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .speed(speed), .duty(duty), .ccr(ccr)
  );

  scl_phase_len #(.CCR_W(CCR_W), .CNT_W(CNT_W)) u_len (
    .speed(speed), .duty(duty), .ccr(ccr),
    .high_len(high_len), .low_len(low_len), .zero_ccr(zero_ccr)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .enable(enable), .zero_ccr(zero_ccr),
    .high_len(high_len), .low_len(low_len),
    .scl_o(scl_o), .scl_fall(scl_fall), .scl_rise(scl_rise), .cfg_err(cfg_err)
  );

endmodule

// File: tb/test_scl_period_gen.sv
`timescale 1ns/1ps
module test_scl_period_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       scl, fall, rise, err;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  scl_period_gen i_scl_period_gen (
    .clk(clk), .rst(rst), .enable(en), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .scl_o(scl),
    .scl_fall(fall), .scl_rise(rise), .cfg_err(err)
  );

  // {mode, duty, ccr[11:0], high[15:0], low[15:0]}
  localparam int NV = 6;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd3,   16'd3,   16'd3},
    {1'b0, 1'b0, 12'd1,   16'd1,   16'd1},
    {1'b0, 1'b0, 12'h028, 16'd40,  16'd40},
    {1'b1, 1'b0, 12'd3,   16'd3,   16'd6},
    {1'b1, 1'b1, 12'd2,   16'd18,  16'd32},
    {1'b1, 1'b1, 12'd1,   16'd9,   16'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic setup(input logic m, input logic du, input logic [11:0] c);
    wr(1'b1, {m, du, 2'b00, c[11:8]});
    wr(1'b0, c[7:0]);
  endtask

  // enable, measure first high and low phase, then disable
  task automatic measure(input int h, input int l, input string req);
    int k = 0, kf = -1, kr = -1;
    @(negedge clk); en = 1'b1;
    while (kr < 0 && k < h + l + 20) begin
      @(posedge clk); #1; k++;
      if (fall && kf < 0) begin
        kf = k;
        check(scl == 1'b0, {req, " scl low with fall strobe"}, scl, 0);
      end
      if (rise && kf >= 0 && kr < 0) kr = k;
    end
    check(kf - 1 == h, {req, " high phase"}, kf - 1, h);
    check(kr - kf == l, {req, " low phase"}, kr - kf, l);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R6: reset state
    #1;
    check(scl == 1'b1, "R6 scl", scl, 1);
    check(!fall && !rise, "R6 strobes", fall | rise, 0);
    check(err == 1'b0, "R6 cfg_err", err, 0);
    rd(1'b1, d); check(d == 8'h00, "R6 hi cfg", d, 0);
    rd(1'b0, d); check(d == 8'h00, "R6 lo cfg", d, 0);

    // R1 R2 R3 R8: vector table
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][45], VEC[i][44], VEC[i][43:32]);
      if (!VEC[i][45])      measure(int'(VEC[i][31:16]), int'(VEC[i][15:0]), "R1/R8 std");
      else if (!VEC[i][44]) measure(int'(VEC[i][31:16]), int'(VEC[i][15:0]), "R2/R8 fast");
      else                  measure(int'(VEC[i][31:16]), int'(VEC[i][15:0]), "R3/R8 fast916");
    end

    // R4: field layout, reserved bits read zero
    wr(1'b1, 8'hFF); wr(1'b0, 8'hA5);
    rd(1'b1, d); check(d == 8'hCF, "R4 hi readback", d, 8'hCF);
    rd(1'b0, d); check(d == 8'hA5, "R4 lo readback", d, 8'hA5);

    // R5: writes while enabled are dropped
    setup(1'b0, 1'b0, 12'd5);
    @(negedge clk); en = 1'b1;
    wr(1'b1, 8'hC3); wr(1'b0, 8'h11);
    rd(1'b1, d); check(d == 8'h00, "R5 hi locked", d, 0);
    rd(1'b0, d); check(d == 8'h05, "R5 lo locked", d, 5);
    @(negedge clk); en = 1'b0;
    measure(5, 5, "R5 timing kept");

    // R7: zero divider
    setup(1'b0, 1'b0, 12'd0);
    begin
      int bad = 0, noerr = 0;
      @(negedge clk); en = 1'b1;
      for (int k = 1; k <= 30; k++) begin
        @(posedge clk); #1;
        if (!scl || fall || rise) bad++;
        if (!err) noerr++;
      end
      check(bad == 0, "R7 scl held high", bad, 0);
      check(noerr == 0, "R7 cfg_err set", noerr, 0);
      @(negedge clk); en = 1'b0;
      @(posedge clk); #1;
      check(err == 1'b0, "R7 cfg_err clears", err, 0);
    end

    // R9 R10: disable during low phase, then restart
    setup(1'b0, 1'b0, 12'd4);
    begin
      int k = 0;
      @(negedge clk); en = 1'b1;
      while (!fall && k < 50) begin @(posedge clk); #1; k++; end
      @(posedge clk); #1;
      check(fall == 1'b0, "R10 fall lasts one cycle", fall, 0);
      check(scl == 1'b0, "R10 scl stays low", scl, 0);
      @(negedge clk); en = 1'b0;
      @(posedge clk); #1;
      check(scl == 1'b1, "R9 released high", scl, 1);
      check(!fall && !rise, "R9 no strobe on disable", fall | rise, 0);
      @(negedge clk);
    end
    measure(4, 4, "R9 restart full high");

    // R11: full-scale divider
    setup(1'b1, 1'b1, 12'hFFF);
    measure(36855, 65520, "R11 full scale");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule